// File: doc/BRIEF.md
# Per-Channel Gamma Correction Stage

This block applies a programmable transfer curve to an RGB video stream. Each beat on the input stream carries four pixels of 24 bits. Every 8-bit colour component of those pixels is replaced by the entry that its value selects in that colour's own 256-entry table. All twelve lookups of a beat happen in the same cycle, so one beat leaves per clock at full rate. The result goes out on an output stream with the same framing.

Software loads the three curves and a pass-through switch over an AXI4-Lite register port. Table writes land in a shadow copy. The shadow copy moves into the live tables only when a start-of-frame beat is accepted, so the curve never changes partway through a picture. A synchronous pipeline flush input discards beats in flight, for example when the resolution changes. The flush leaves the tables and the pass-through switch untouched.

Top module: `gamma_lut`

## Requirements
- R1: After rst_ni is released, m_axis_tvalid_o is 0, s_axis_tready_o is 1, the pass-through bit reads 0, and every live and shadow table entry equals its own index. As a result, output components equal input components until the first table write has been committed.
- R2: Stream data packs pixel p (0 to 3) at tdata bits [24p+23:24p]. Within a pixel, red is at bits [7:0], green at [15:8] and blue at [23:16]. Each output component equals the live table entry of its colour, indexed by the matching input component.
- R3: Red, green and blue each use their own table. A write to one colour's table changes no other colour's output.
- R4: With m_axis_tready_i held high, a beat accepted on a clock edge appears on the output after exactly two clock edges. Its tuser (start of frame) and tlast (end of line) come out with it.
- R5: s_axis_tready_o is low only while the output holds a beat that is not being taken. While m_axis_tvalid_o is high and m_axis_tready_i is low, the output beat stays unchanged. Every accepted beat comes out exactly once and in order.
- R6: Bit 0 of the control register (byte address 0x000) selects pass-through. When it is set, input components reach the output unchanged with the same two-cycle latency.
- R7: A write to byte address {sel[1:0], index[7:0], 2'b00} stores data bits [7:0] into the shadow entry of red (sel=1), green (sel=2) or blue (sel=3). A read from the same address returns that shadow entry, zero-extended.
- R8: Table writes leave the output unchanged until a beat with tuser=1 is accepted. That beat and every later beat use the complete shadow contents.
- R9: Asserting sw_rst_i for one cycle drops every beat in flight, so m_axis_tvalid_o is 0 from the next edge on. Table contents and the pass-through bit are kept.
- R10: Writes and reads complete with response OKAY (2'b00) and allow one transaction at a time in each direction. A misaligned address, or a write with data bits set above the target field (above bit 0 for control, above bit 7 for a table), answers SLVERR (2'b10) and has no effect. A write with all strobes zero answers OKAY and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sw_rst_i | input | 1 | Synchronous pipeline flush |
| s_axis_tdata_i | input | 96 | Input pixels, four per beat |
| s_axis_tuser_i | input | 1 | Input start of frame |
| s_axis_tlast_i | input | 1 | Input end of line |
| s_axis_tvalid_i | input | 1 | Input beat valid |
| s_axis_tready_o | output | 1 | Input beat accepted |
| m_axis_tdata_o | output | 96 | Corrected pixels |
| m_axis_tuser_o | output | 1 | Output start of frame |
| m_axis_tlast_o | output | 1 | Output end of line |
| m_axis_tvalid_o | output | 1 | Output beat valid |
| m_axis_tready_i | input | 1 | Downstream ready |
| s_axil_awaddr_i | input | 12 | Write address |
| s_axil_awvalid_i | input | 1 | Write address valid |
| s_axil_awready_o | output | 1 | Write address ready |
| s_axil_wdata_i | input | 32 | Write data |
| s_axil_wstrb_i | input | 4 | Write strobes |
| s_axil_wvalid_i | input | 1 | Write data valid |
| s_axil_wready_o | output | 1 | Write data ready |
| s_axil_bresp_o | output | 2 | Write response |
| s_axil_bvalid_o | output | 1 | Write response valid |
| s_axil_bready_i | input | 1 | Write response ready |
| s_axil_araddr_i | input | 12 | Read address |
| s_axil_arvalid_i | input | 1 | Read address valid |
| s_axil_arready_o | output | 1 | Read address ready |
| s_axil_rdata_o | output | 32 | Read data |
| s_axil_rresp_o | output | 2 | Read response |
| s_axil_rvalid_o | output | 1 | Read data valid |
| s_axil_rready_i | input | 1 | Read data ready |

## Verification
The bench builds the block with its default parameters: four lanes and 8-bit components. At that width each table has only 256 entries. That makes every stage of the check exhaustive:
- Each colour is loaded with a different arithmetic curve, and every entry of every table is read back.
- Sweep frames walk all 256 index values through all four lanes.

Frames are also sent with random valid gaps and random downstream stalls. Other cases are driven directly:
- a write in the middle of a frame, followed by a start-of-frame beat;
- pass-through mode;
- the two-edge latency;
- a flush with a beat in flight;
- rejected register writes.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
  localparam int NCH = 3;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_RED  = 2'd1,
    SEL_GRN  = 2'd2,
    SEL_BLU  = 2'd3
  } sel_e;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;
endpackage

// File: rtl/gamma_lut_axil.sv
module gamma_lut_axil
  import gamma_lut_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CW+3:0]     awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [31:0]       wdata_i,
  input  logic [3:0]        wstrb_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic [1:0]        bresp_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  input  logic [CW+3:0]     araddr_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic [31:0]       rdata_o,
  output logic [1:0]        rresp_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  output logic              bypass_o,
  output logic              tbl_we_o,
  output logic [1:0]        tbl_ch_o,
  output logic [CW-1:0]     tbl_idx_o,
  output logic [CW-1:0]     tbl_val_o,
  output logic [1:0]        rd_ch_o,
  output logic [CW-1:0]     rd_idx_o,
  input  logic [CW-1:0]     rd_val_i
);
  localparam int AW = CW + 4;

  sel_e wsel, rsel;
  logic wr_fire, w_ok, w_fits, w_apply, rd_fire, r_ok;
  logic bypass_q, bvalid_q, rvalid_q;
  logic [1:0] bresp_q, rresp_q;
  logic [31:0] rdata_q;

  assign wsel    = sel_e'(awaddr_i[AW-1 -: 2]);
  assign rsel    = sel_e'(araddr_i[AW-1 -: 2]);
  assign wr_fire = awvalid_i & wvalid_i & ~bvalid_q;
  assign w_fits  = (wsel == SEL_CTRL) ? (wdata_i[31:1] == '0) : (wdata_i[31:CW] == '0);
  assign w_ok    = (awaddr_i[1:0] == 2'b00) & w_fits;
  assign w_apply = wr_fire & w_ok & (|wstrb_i);
  assign rd_fire = arvalid_i & ~rvalid_q;
  assign r_ok    = (araddr_i[1:0] == 2'b00);

  assign awready_o = wr_fire;
  assign wready_o  = wr_fire;
  assign arready_o = ~rvalid_q;
  assign bvalid_o  = bvalid_q;
  assign bresp_o   = bresp_q;
  assign rvalid_o  = rvalid_q;
  assign rresp_o   = rresp_q;
  assign rdata_o   = rdata_q;
  assign bypass_o  = bypass_q;

  assign tbl_we_o  = w_apply & (wsel != SEL_CTRL);
  assign tbl_ch_o  = 2'(wsel) - 2'd1;
  assign tbl_idx_o = awaddr_i[2 +: CW];
  assign tbl_val_o = wdata_i[CW-1:0];
  assign rd_ch_o   = 2'(rsel) - 2'd1;
  assign rd_idx_o  = araddr_i[2 +: CW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bvalid_q <= 1'b0;
      bresp_q  <= RESP_OKAY;
      bypass_q <= 1'b0;
    end else begin
      if (wr_fire) begin
        bvalid_q <= 1'b1;
        bresp_q  <= w_ok ? RESP_OKAY : RESP_SLVERR;
      end else if (bready_i) begin
        bvalid_q <= 1'b0;
      end
      if (w_apply && wsel == SEL_CTRL) bypass_q <= wdata_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rresp_q  <= RESP_OKAY;
      rdata_q  <= '0;
    end else if (rd_fire) begin
      rvalid_q <= 1'b1;
      rresp_q  <= r_ok ? RESP_OKAY : RESP_SLVERR;
      if (!r_ok)                 rdata_q <= '0;
      else if (rsel == SEL_CTRL) rdata_q <= {31'b0, bypass_q};
      else                       rdata_q <= 32'(rd_val_i);
    end else if (rready_i) begin
      rvalid_q <= 1'b0;
    end
  end

  p_bhold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bvalid_o && !bready_i |=> bvalid_o && $stable(bresp_o));
  p_one_wr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bvalid_o |-> !awready_o);
  p_rhold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o && !rready_i |=> rvalid_o && $stable(rdata_o));
endmodule

// File: rtl/gamma_lut_tables.sv
module gamma_lut_tables
  import gamma_lut_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CW    = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [1:0]                wr_ch_i,
  input  logic [CW-1:0]             wr_idx_i,
  input  logic [CW-1:0]             wr_val_i,
  input  logic [1:0]                rd_ch_i,
  input  logic [CW-1:0]             rd_idx_i,
  output logic [CW-1:0]             rd_val_o,
  input  logic                      commit_i,
  input  logic [LANES*NCH*CW-1:0]   idx_i,
  output logic [LANES*NCH*CW-1:0]   val_o
);
  localparam int DEPTH = 1 << CW;
  localparam int PIXW  = NCH * CW;

  logic [CW-1:0] shadow_q [NCH][DEPTH];
  logic [CW-1:0] active_q [NCH][DEPTH];
  logic          pending_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      for (int c = 0; c < NCH; c++) begin
        for (int e = 0; e < DEPTH; e++) begin
          shadow_q[c][e] <= CW'(e);
          active_q[c][e] <= CW'(e);
        end
      end
    end else begin
      if (commit_i && pending_q) active_q <= shadow_q;
      for (int c = 0; c < NCH; c++) begin
        if (wr_en_i && wr_ch_i == 2'(c)) shadow_q[c][wr_idx_i] <= wr_val_i;
      end
      // a write landing on the commit cycle keeps the flag for the next frame
      if (wr_en_i)       pending_q <= 1'b1;
      else if (commit_i) pending_q <= 1'b0;
    end
  end

  always_comb begin
    case (rd_ch_i)
      2'd0:    rd_val_o = shadow_q[0][rd_idx_i];
      2'd1:    rd_val_o = shadow_q[1][rd_idx_i];
      2'd2:    rd_val_o = shadow_q[2][rd_idx_i];
      default: rd_val_o = '0;
    endcase
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign val_o[l*PIXW + c*CW +: CW] = active_q[c][idx_i[l*PIXW + c*CW +: CW]];
    end
  end

  p_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit_i && pending_q) && $stable(idx_i) ##1 $stable(idx_i) |-> $stable(val_o));
endmodule

// File: rtl/gamma_lut_pipe.sv
module gamma_lut_pipe
  import gamma_lut_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CW    = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sw_rst_i,
  input  logic                      bypass_i,
  input  logic [LANES*NCH*CW-1:0]   s_tdata_i,
  input  logic                      s_tuser_i,
  input  logic                      s_tlast_i,
  input  logic                      s_tvalid_i,
  output logic                      s_tready_o,
  output logic [LANES*NCH*CW-1:0]   m_tdata_o,
  output logic                      m_tuser_o,
  output logic                      m_tlast_o,
  output logic                      m_tvalid_o,
  input  logic                      m_tready_i,
  output logic [LANES*NCH*CW-1:0]   lut_idx_o,
  input  logic [LANES*NCH*CW-1:0]   lut_val_i,
  output logic                      sof_o
);
  localparam int DW = LANES * NCH * CW;

  logic          en;
  logic          v1_q, v2_q, u1_q, u2_q, l1_q, l2_q;
  logic [DW-1:0] d1_q, d2_q;

  // one enable for both stages: a stalled output freezes everything
  assign en         = m_tready_i | ~v2_q;
  assign s_tready_o = en;
  assign sof_o      = s_tvalid_i & en & s_tuser_i & ~sw_rst_i;
  assign lut_idx_o  = d1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      u1_q <= 1'b0;
      u2_q <= 1'b0;
      l1_q <= 1'b0;
      l2_q <= 1'b0;
      d1_q <= '0;
      d2_q <= '0;
    end else if (sw_rst_i) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else if (en) begin
      v1_q <= s_tvalid_i;
      v2_q <= v1_q;
      if (s_tvalid_i) begin
        d1_q <= s_tdata_i;
        u1_q <= s_tuser_i;
        l1_q <= s_tlast_i;
      end
      if (v1_q) begin
        d2_q <= bypass_i ? d1_q : lut_val_i;
        u2_q <= u1_q;
        l2_q <= l1_q;
      end
    end
  end

  assign m_tdata_o  = d2_q;
  assign m_tuser_o  = u2_q;
  assign m_tlast_o  = l2_q;
  assign m_tvalid_o = v2_q;

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_o && !m_tready_i && !sw_rst_i |=> m_tvalid_o && $stable(m_tdata_o)
      && $stable(m_tuser_o) && $stable(m_tlast_o));
  p_fill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_tvalid_i && s_tready_o && !sw_rst_i) ##1 (!sw_rst_i && m_tready_i) |=> m_tvalid_o);
  p_flush_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |=> !m_tvalid_o);
endmodule

// File: rtl/gamma_lut.sv
module gamma_lut
  import gamma_lut_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CW    = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sw_rst_i,
  input  logic [LANES*3*CW-1:0]   s_axis_tdata_i,
  input  logic                    s_axis_tuser_i,
  input  logic                    s_axis_tlast_i,
  input  logic                    s_axis_tvalid_i,
  output logic                    s_axis_tready_o,
  output logic [LANES*3*CW-1:0]   m_axis_tdata_o,
  output logic                    m_axis_tuser_o,
  output logic                    m_axis_tlast_o,
  output logic                    m_axis_tvalid_o,
  input  logic                    m_axis_tready_i,
  input  logic [CW+3:0]           s_axil_awaddr_i,
  input  logic                    s_axil_awvalid_i,
  output logic                    s_axil_awready_o,
  input  logic [31:0]             s_axil_wdata_i,
  input  logic [3:0]              s_axil_wstrb_i,
  input  logic                    s_axil_wvalid_i,
  output logic                    s_axil_wready_o,
  output logic [1:0]              s_axil_bresp_o,
  output logic                    s_axil_bvalid_o,
  input  logic                    s_axil_bready_i,
  input  logic [CW+3:0]           s_axil_araddr_i,
  input  logic                    s_axil_arvalid_i,
  output logic                    s_axil_arready_o,
  output logic [31:0]             s_axil_rdata_o,
  output logic [1:0]              s_axil_rresp_o,
  output logic                    s_axil_rvalid_o,
  input  logic                    s_axil_rready_i
);
  localparam int DW = LANES * NCH * CW;

  logic          bypass, tbl_we, commit;
  logic [1:0]    tbl_ch, rd_ch;
  logic [CW-1:0] tbl_idx, tbl_val, rd_idx, rd_val;
  logic [DW-1:0] lut_idx, lut_val;

  gamma_lut_axil #(.CW(CW)) u_axil (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .awaddr_i  (s_axil_awaddr_i),
    .awvalid_i (s_axil_awvalid_i),
    .awready_o (s_axil_awready_o),
    .wdata_i   (s_axil_wdata_i),
    .wstrb_i   (s_axil_wstrb_i),
    .wvalid_i  (s_axil_wvalid_i),
    .wready_o  (s_axil_wready_o),
    .bresp_o   (s_axil_bresp_o),
    .bvalid_o  (s_axil_bvalid_o),
    .bready_i  (s_axil_bready_i),
    .araddr_i  (s_axil_araddr_i),
    .arvalid_i (s_axil_arvalid_i),
    .arready_o (s_axil_arready_o),
    .rdata_o   (s_axil_rdata_o),
    .rresp_o   (s_axil_rresp_o),
    .rvalid_o  (s_axil_rvalid_o),
    .rready_i  (s_axil_rready_i),
    .bypass_o  (bypass),
    .tbl_we_o  (tbl_we),
    .tbl_ch_o  (tbl_ch),
    .tbl_idx_o (tbl_idx),
    .tbl_val_o (tbl_val),
    .rd_ch_o   (rd_ch),
    .rd_idx_o  (rd_idx),
    .rd_val_i  (rd_val)
  );

  gamma_lut_tables #(.LANES(LANES), .CW(CW)) u_tables (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (tbl_we),
    .wr_ch_i  (tbl_ch),
    .wr_idx_i (tbl_idx),
    .wr_val_i (tbl_val),
    .rd_ch_i  (rd_ch),
    .rd_idx_i (rd_idx),
    .rd_val_o (rd_val),
    .commit_i (commit),
    .idx_i    (lut_idx),
    .val_o    (lut_val)
  );

  gamma_lut_pipe #(.LANES(LANES), .CW(CW)) u_pipe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sw_rst_i   (sw_rst_i),
    .bypass_i   (bypass),
    .s_tdata_i  (s_axis_tdata_i),
    .s_tuser_i  (s_axis_tuser_i),
    .s_tlast_i  (s_axis_tlast_i),
    .s_tvalid_i (s_axis_tvalid_i),
    .s_tready_o (s_axis_tready_o),
    .m_tdata_o  (m_axis_tdata_o),
    .m_tuser_o  (m_axis_tuser_o),
    .m_tlast_o  (m_axis_tlast_o),
    .m_tvalid_o (m_axis_tvalid_o),
    .m_tready_i (m_axis_tready_i),
    .lut_idx_o  (lut_idx),
    .lut_val_i  (lut_val),
    .sof_o      (commit)
  );
endmodule

// File: tb/gamma_lut_tb_top.sv
module gamma_lut_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_rst = 1'b0;
  logic [95:0] s_tdata = '0;
  logic s_tuser = 1'b0, s_tlast = 1'b0, s_tvalid = 1'b0;
  logic s_tready;
  logic [95:0] m_tdata;
  logic m_tuser, m_tlast, m_tvalid;
  logic m_tready = 1'b1;
  logic [11:0] awaddr = '0, araddr = '0;
  logic awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
  logic awready, wready, bvalid, arready, rvalid;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;

  always #5 clk = ~clk;

  gamma_lut dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sw_rst_i(sw_rst),
    .s_axis_tdata_i(s_tdata), .s_axis_tuser_i(s_tuser), .s_axis_tlast_i(s_tlast),
    .s_axis_tvalid_i(s_tvalid), .s_axis_tready_o(s_tready),
    .m_axis_tdata_o(m_tdata), .m_axis_tuser_o(m_tuser), .m_axis_tlast_o(m_tlast),
    .m_axis_tvalid_o(m_tvalid), .m_axis_tready_i(m_tready),
    .s_axil_awaddr_i(awaddr), .s_axil_awvalid_i(awvalid), .s_axil_awready_o(awready),
    .s_axil_wdata_i(wdata), .s_axil_wstrb_i(wstrb), .s_axil_wvalid_i(wvalid),
    .s_axil_wready_o(wready), .s_axil_bresp_o(bresp), .s_axil_bvalid_o(bvalid),
    .s_axil_bready_i(1'b1), .s_axil_araddr_i(araddr), .s_axil_arvalid_i(arvalid),
    .s_axil_arready_o(arready), .s_axil_rdata_o(rdata), .s_axil_rresp_o(rresp),
    .s_axil_rvalid_o(rvalid), .s_axil_rready_i(1'b1)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [7:0] sh  [3][256];
  logic [7:0] act [3][256];
  logic       pend = 1'b0, byp = 1'b0;

  logic [95:0] tx_d [256];
  logic        tx_u [256];
  logic        tx_l [256];
  logic [97:0] exp_q [$];

  task automatic chk(input logic ok, input string tag, input logic [127:0] got, input logic [127:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got %0h expected %0h", tag, got, expv);
    end
  endtask

  function automatic logic [95:0] model_out(input logic [95:0] d, input logic bp);
    logic [95:0] r;
    for (int p = 0; p < 4; p++)
      for (int c = 0; c < 3; c++)
        r[24*p + 8*c +: 8] = bp ? d[24*p + 8*c +: 8] : act[c][d[24*p + 8*c +: 8]];
    return r;
  endfunction

  // mode 0: r=v g=v+37 b=3v ; sweeps v over 4 lanes per beat
  task automatic fill(input int n, input int base, input logic sof);
    for (int b = 0; b < n; b++) begin
      for (int p = 0; p < 4; p++) begin
        logic [7:0] v;
        v = 8'((base + b*4 + p) & 255);
        tx_d[b][24*p +: 24] = {8'(v*3), 8'(v + 37), v};
      end
      tx_u[b] = sof && (b == 0);
      tx_l[b] = (b == n-1);
    end
  endtask

  task automatic run_stream(input int n, input logic bp, input string tag);
    int i = 0;
    while (i < n || exp_q.size() > 0) begin
      @(negedge clk);
      m_tready = bp ? ($urandom % 3 != 0) : 1'b1;
      s_tvalid = (i < n) && (bp ? ($urandom % 4 != 0) : 1'b1);
      s_tdata  = tx_d[(i < n) ? i : 0];
      s_tuser  = tx_u[(i < n) ? i : 0];
      s_tlast  = tx_l[(i < n) ? i : 0];
      #1;
      if (m_tvalid && m_tready) begin
        logic [97:0] e;
        if (exp_q.size() == 0) begin
          chk(1'b0, {tag, " unexpected beat"}, {30'b0, m_tuser, m_tlast, m_tdata}, 0);
        end else begin
          e = exp_q.pop_front();
          chk({m_tuser, m_tlast, m_tdata} == e, tag, {30'b0, m_tuser, m_tlast, m_tdata}, {30'b0, e});
        end
      end
      if (s_tvalid && s_tready) begin
        if (s_tuser && pend) begin
          act  = sh;
          pend = 1'b0;
        end
        exp_q.push_back({s_tuser, s_tlast, model_out(s_tdata, byp)});
        i++;
      end
    end
    @(negedge clk);
    s_tvalid = 1'b0;
    m_tready = 1'b1;
  endtask

  task automatic axi_wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] st, output logic [1:0] resp);
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = st; awvalid = 1'b1; wvalid = 1'b1;
    #1;
    while (!awready) begin @(negedge clk); #1; end
    @(negedge clk);
    awvalid = 1'b0; wvalid = 1'b0;
    resp = bresp;
  endtask

  task automatic axi_rd(input logic [11:0] a, output logic [31:0] d, output logic [1:0] resp);
    @(negedge clk);
    araddr = a; arvalid = 1'b1;
    #1;
    while (!arready) begin @(negedge clk); #1; end
    @(negedge clk);
    arvalid = 1'b0;
    d = rdata; resp = rresp;
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d, input logic [3:0] st,
                        input logic [1:0] exp_resp, input string tag);
    logic [1:0] r;
    axi_wr(a, d, st, r);
    chk(r == exp_resp, tag, r, exp_resp);
    if (exp_resp == 2'b00 && st != 4'b0) begin
      if (a[11:10] == 2'd0) byp = d[0];
      else begin
        sh[a[11:10] - 2'd1][a[9:2]] = d[7:0];
        pend = 1'b1;
      end
    end
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] expv, input string tag);
    logic [31:0] d;
    logic [1:0] r;
    axi_rd(a, d, r);
    chk(d == expv && r == 2'b00, tag, {r, d}, {2'b00, expv});
  endtask

  function automatic logic [7:0] curve(input int c, input int i);
    case (c)
      0:       return 8'(255 - i);
      1:       return 8'(i*5 + 3);
      default: return 8'(i) ^ 8'hA5;
    endcase
  endfunction

  initial begin
    for (int c = 0; c < 3; c++)
      for (int e = 0; e < 256; e++) begin
        sh[c][e]  = 8'(e);
        act[c][e] = 8'(e);
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(m_tvalid == 1'b0 && s_tready == 1'b1, "R1 reset handshake", {m_tvalid, s_tready}, 2'b01);
    rd_chk(12'h000, 32'd0, "R1 control after reset");
    rd_chk({2'd2, 8'd77, 2'b00}, 32'd77, "R1 shadow identity after reset");

    // identity through the live tables before any write
    fill(64, 0, 1'b1);
    run_stream(64, 1'b0, "R1 identity frame");

    // distinct curves per colour
    for (int c = 0; c < 3; c++)
      for (int e = 0; e < 256; e++)
        wr_reg({2'(c + 1), 8'(e), 2'b00}, 32'(curve(c, e)), 4'hF, 2'b00, "R10 table write resp");
    for (int c = 0; c < 3; c++)
      for (int e = 0; e < 256; e++)
        rd_chk({2'(c + 1), 8'(e), 2'b00}, 32'(curve(c, e)), "R7 shadow readback");

    // writes not yet committed: a frame without start marker keeps old curve
    fill(32, 5, 1'b0);
    run_stream(32, 1'b0, "R8 before commit");

    // start marker commits; exhaustive sweep of all indices per colour
    fill(64, 0, 1'b1);
    run_stream(64, 1'b0, "R2 R3 committed sweep");

    // random stalls and gaps
    fill(200, 17, 1'b1);
    run_stream(200, 1'b1, "R5 backpressure");

    // mid-frame writes deferred to next start of frame
    for (int e = 0; e < 256; e += 3)
      wr_reg({2'd2, 8'(e), 2'b00}, 32'(8'(e) ^ 8'h3C), 4'hF, 2'b00, "R10 green rewrite resp");
    fill(64, 0, 1'b0);
    run_stream(64, 1'b0, "R8 mid frame old curve");
    fill(64, 0, 1'b1);
    run_stream(64, 1'b1, "R8 new curve after start");

    // rejected and no-op writes
    wr_reg({2'd1, 8'd9, 2'b01}, 32'h11, 4'hF, 2'b10, "R10 misaligned write");
    wr_reg({2'd1, 8'd9, 2'b00}, 32'h1FF, 4'hF, 2'b10, "R10 oversize data");
    wr_reg({2'd1, 8'd9, 2'b00}, 32'h22, 4'h0, 2'b00, "R10 zero strobe");
    wr_reg(12'h000, 32'h2, 4'hF, 2'b10, "R10 oversize control");
    rd_chk({2'd1, 8'd9, 2'b00}, 32'(sh[0][9]), "R10 rejected writes left entry");
    rd_chk(12'h000, 32'd0, "R10 rejected control left bypass");
    begin
      logic [31:0] d;
      logic [1:0] r;
      axi_rd({2'd1, 8'd9, 2'b10}, d, r);
      chk(r == 2'b10 && d == 32'd0, "R10 misaligned read", {r, d}, {2'b10, 32'd0});
    end

    // pass-through
    wr_reg(12'h000, 32'h1, 4'hF, 2'b00, "R6 set bypass");
    rd_chk(12'h000, 32'd1, "R6 control readback");
    fill(64, 3, 1'b1);
    run_stream(64, 1'b1, "R6 bypass sweep");
    wr_reg(12'h000, 32'h0, 4'hF, 2'b00, "R6 clear bypass");

    // latency: count edges from acceptance to output valid
    begin
      int edges = 0;
      @(negedge clk);
      m_tready = 1'b1;
      s_tdata = {8'd1, 8'd2, 8'd3, 72'h0};
      s_tuser = 1'b1; s_tlast = 1'b1; s_tvalid = 1'b1;
      if (pend) begin act = sh; pend = 1'b0; end
      #1;
      chk(s_tready == 1'b1, "R4 accept", s_tready, 1);
      @(negedge clk);
      s_tvalid = 1'b0; s_tuser = 1'b0; s_tlast = 1'b0;
      edges = 1;
      #1;
      while (!m_tvalid && edges < 8) begin @(negedge clk); edges++; #1; end
      chk(edges == 2, "R4 latency edges", edges, 2);
      chk(m_tuser && m_tlast && m_tdata == model_out({8'd1, 8'd2, 8'd3, 72'h0}, 1'b0),
          "R4 aligned sideband", {m_tuser, m_tlast, m_tdata},
          {1'b1, 1'b1, model_out({8'd1, 8'd2, 8'd3, 72'h0}, 1'b0)});
    end

    // flush with a beat in flight
    @(negedge clk);
    m_tready = 1'b0;
    s_tdata = 96'h123456; s_tuser = 1'b0; s_tlast = 1'b0; s_tvalid = 1'b1;
    @(negedge clk);
    s_tvalid = 1'b0;
    sw_rst = 1'b1;
    @(negedge clk);
    sw_rst = 1'b0;
    #1;
    chk(m_tvalid == 1'b0, "R9 flush immediate", m_tvalid, 0);
    repeat (3) @(negedge clk);
    #1;
    chk(m_tvalid == 1'b0 && s_tready == 1'b1, "R9 flush stays empty", {m_tvalid, s_tready}, 2'b01);
    m_tready = 1'b1;
    fill(16, 40, 1'b0);
    run_stream(16, 1'b0, "R9 tables kept after flush");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R5 watchdog got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule